// File: doc/BRIEF.md
# Paper Tape Reader Controller

This block is the device side of a paper tape reader attached to a programmed-I/O bus. The processor issues one of four instruction classes: control, skip test, input and output. Each instruction arrives with a function code, a data word and a one-cycle strobe. The controller answers in the same cycle. Its answer is a possibly modified data word, a skip indication and a flag for an illegal function code.

Internally the controller holds four pieces of state: a motion flag, a ready flag, a fetch-pending flag and an 8-bit character buffer. A character source with a valid/ready handshake stands in for the tape mechanism. The controller asks for a character only while tape motion is on and a fetch is outstanding. When the processor takes a character while motion is still on, the controller asks for the next one by itself. The interrupt request is the ready flag gated by an externally supplied enable bit.

Top module: `tape_reader_ctrl`

## Requirements
- R1: After reset, motion, ready and fetch-pending are clear, so `src_ready` and `int_req` are 0.
- R2: A control instruction (`io_op` = 0) with function 0 turns motion on and requests a character, so `src_ready` is 1 from the next cycle. Function 1 turns motion off and cancels the request, so `src_ready` is 0 from the next cycle.
- R3: A control instruction whose function code has any of bits 3..1 set raises `io_bad_func` in its strobe cycle and changes no state.
- R4: When `src_valid` and `src_ready` are both high at a clock edge, the buffer loads `src_char`, ready sets and the request drops. `src_valid` has no effect while `src_ready` is low.
- R5: A skip instruction (`io_op` = 1) with function 0 asserts `io_skip` exactly when ready is set. With function 4 it asserts `io_skip` exactly when `int_req` is low.
- R6: A skip instruction whose function code has any of bits 3, 1 or 0 set raises `io_bad_func` and never skips.
- R7: An input instruction (`io_op` = 2) with function 0 issued while ready returns `io_data_in` OR the zero-extended buffer, asserts `io_skip`, and clears ready from the next cycle.
- R8: An input instruction with function 0 issued while not ready returns `io_data_in` unchanged, with no skip and no bad-function flag.
- R9: An input instruction with a nonzero function raises `io_bad_func`, returns the data unchanged and leaves ready as it was.
- R10: A character taken by R7 while motion is on makes `src_ready` rise in the next cycle. With motion off, `src_ready` stays low.
- R11: `int_req` is high exactly when ready is set and `int_enable` is high.
- R12: An output instruction (`io_op` = 3) returns the data unchanged with no skip and no bad flag. It also leaves the buffer and ready untouched.
- R13: While `io_strobe` is low, `io_skip` and `io_bad_func` are 0 and `io_data_out` equals `io_data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_strobe | input | 1 | Instruction strobe, one cycle |
| io_op | input | 2 | Instruction class: 0 control, 1 skip, 2 input, 3 output |
| io_func | input | 4 | Function code |
| io_data_in | input | 16 | Data word from the processor |
| io_data_out | output | 16 | Returned data word |
| io_skip | output | 1 | Skip indication |
| io_bad_func | output | 1 | Illegal function code for this class |
| int_enable | input | 1 | Interrupt mask bit for this device |
| int_req | output | 1 | Interrupt request |
| src_valid | input | 1 | Character source has a character |
| src_char | input | 8 | Character from the source |
| src_ready | output | 1 | Controller accepts a character |

## Verification
The data, skip and bad-function answers are combinational and belong to the strobe cycle itself. The bench drives every input at a falling edge and reads these answers 1 ns later, before the next rising edge. State effects go through one register stage: ready, the fetch request, `src_ready` and `int_req` change at the rising edge that ends the strobe or handshake cycle. The bench reads them at the following falling edge. Internal state is observed only through ports, using a skip-on-ready instruction or an input instruction.

// File: rtl/tape_rdr_pkg.sv
package tape_rdr_pkg;

    typedef enum logic [1:0] {
        OP_CTRL   = 2'd0,
        OP_SKIP   = 2'd1,
        OP_INPUT  = 2'd2,
        OP_OUTPUT = 2'd3
    } io_op_e;

    // Decoded, qualified instruction: every field is already gated by strobe
    typedef struct packed {
        logic ctrl_start;
        logic ctrl_stop;
        logic ctrl_bad;
        logic skip_rdy;
        logic skip_noint;
        logic skip_bad;
        logic in_take;
        logic in_bad;
    } dec_t;

endpackage

// File: rtl/tape_rdr_decode.sv
module tape_rdr_decode
    import tape_rdr_pkg::*;
#(
    parameter int FUNC_W = 4
) (
    input  logic              strobe,
    input  logic [1:0]        op,
    input  logic [FUNC_W-1:0] func,
    output dec_t              dec
);
    // Illegal-bit masks: control allows codes 0,1; skip allows codes 0,4
    localparam logic [FUNC_W-1:0] CTRL_ILLEGAL = ~FUNC_W'(1);
    localparam logic [FUNC_W-1:0] SKIP_ILLEGAL = ~FUNC_W'(4);
    localparam logic [FUNC_W-1:0] SKIP_NOINT   = FUNC_W'(4);

    io_op_e op_e;
    logic   is_ctrl, is_skip, is_in;
    logic   ctrl_ok, skip_ok, func_zero;

    always_comb begin
        op_e      = io_op_e'(op);
        is_ctrl   = strobe && (op_e == OP_CTRL);
        is_skip   = strobe && (op_e == OP_SKIP);
        is_in     = strobe && (op_e == OP_INPUT);
        func_zero = (func == '0);
        ctrl_ok   = ((func & CTRL_ILLEGAL) == '0);
        skip_ok   = ((func & SKIP_ILLEGAL) == '0);

        dec            = '0;
        dec.ctrl_start = is_ctrl && ctrl_ok && !func[0];
        dec.ctrl_stop  = is_ctrl && ctrl_ok &&  func[0];
        dec.ctrl_bad   = is_ctrl && !ctrl_ok;
        dec.skip_rdy   = is_skip && func_zero;
        dec.skip_noint = is_skip && (func == SKIP_NOINT);
        dec.skip_bad   = is_skip && !skip_ok;
        dec.in_take    = is_in && func_zero;
        dec.in_bad     = is_in && !func_zero;
    end

endmodule

// File: rtl/tape_rdr_core.sv
module tape_rdr_core #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              take,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_char,
    output logic              src_ready,
    output logic              ready_q,
    output logic [CHAR_W-1:0] chr_q
);
    typedef struct packed {
        logic              motion;
        logic              ready;
        logic              pending;
        logic [CHAR_W-1:0] chr;
    } rdr_state_t;

    rdr_state_t st_d, st_q;
    logic       capture;

    always_comb begin
        src_ready = st_q.motion && st_q.pending;
        capture   = src_valid && src_ready;
        st_d      = st_q;

        // processor instruction effects
        if (start) begin
            st_d.motion  = 1'b1;
            st_d.pending = 1'b1;
        end
        if (stop) begin
            st_d.motion  = 1'b0;
            st_d.pending = 1'b0;
        end
        if (take && st_q.ready) begin
            st_d.ready = 1'b0;
            if (st_q.motion) begin
                st_d.pending = 1'b1;
            end
        end

        // completed handshake applied last so a character is never lost
        if (capture) begin
            st_d.chr     = src_char;
            st_d.ready   = 1'b1;
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_q = st_q.ready;
    assign chr_q   = st_q.chr;

endmodule

// File: rtl/tape_rdr_respond.sv
module tape_rdr_respond #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic              take,
    input  logic              skip_rdy,
    input  logic              skip_noint,
    input  logic              any_bad,
    input  logic              ready_q,
    input  logic              int_req,
    input  logic [CHAR_W-1:0] chr_q,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              skip,
    output logic              bad
);
    localparam int PAD_W = DATA_W - CHAR_W;

    logic [DATA_W-1:0] chr_ext;
    logic              deliver;

    generate
        if (PAD_W > 0) begin : g_pad
            assign chr_ext = {{PAD_W{1'b0}}, chr_q};
        end else begin : g_trunc
            assign chr_ext = chr_q[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        deliver  = take && ready_q;
        skip     = deliver
                 || (skip_rdy   && ready_q)
                 || (skip_noint && !int_req);
        data_out = deliver ? (data_in | chr_ext) : data_in;
        bad      = any_bad;
    end

endmodule

// File: rtl/tape_reader_ctrl.sv
module tape_reader_ctrl
    import tape_rdr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter int FUNC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_strobe,
    input  logic [1:0]        io_op,
    input  logic [FUNC_W-1:0] io_func,
    input  logic [DATA_W-1:0] io_data_in,
    output logic [DATA_W-1:0] io_data_out,
    output logic              io_skip,
    output logic              io_bad_func,
    input  logic              int_enable,
    output logic              int_req,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_char,
    output logic              src_ready
);
    dec_t              dec;
    logic              ready_q;
    logic [CHAR_W-1:0] chr_q;
    logic              any_bad;

    tape_rdr_decode #(.FUNC_W(FUNC_W)) u_decode (
        .strobe (io_strobe),
        .op     (io_op),
        .func   (io_func),
        .dec    (dec)
    );

    tape_rdr_core #(.CHAR_W(CHAR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dec.ctrl_start),
        .stop      (dec.ctrl_stop),
        .take      (dec.in_take),
        .src_valid (src_valid),
        .src_char  (src_char),
        .src_ready (src_ready),
        .ready_q   (ready_q),
        .chr_q     (chr_q)
    );

    assign int_req = ready_q && int_enable;
    assign any_bad = dec.ctrl_bad || dec.skip_bad || dec.in_bad;

    tape_rdr_respond #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_respond (
        .take       (dec.in_take),
        .skip_rdy   (dec.skip_rdy),
        .skip_noint (dec.skip_noint),
        .any_bad    (any_bad),
        .ready_q    (ready_q),
        .int_req    (int_req),
        .chr_q      (chr_q),
        .data_in    (io_data_in),
        .data_out   (io_data_out),
        .skip       (io_skip),
        .bad        (io_bad_func)
    );

endmodule

// File: rtl/tape_reader_ctrl_chk.sv
module tape_reader_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter int FUNC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_strobe,
    input logic [1:0]        io_op,
    input logic [FUNC_W-1:0] io_func,
    input logic [DATA_W-1:0] io_data_in,
    input logic [DATA_W-1:0] io_data_out,
    input logic              io_skip,
    input logic              io_bad_func,
    input logic              int_enable,
    input logic              int_req,
    input logic              src_valid,
    input logic [CHAR_W-1:0] src_char,
    input logic              src_ready,
    input logic              ready_q,
    input logic [CHAR_W-1:0] chr_q
);
    logic hs;
    assign hs = src_valid && src_ready;

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strobe |-> (!io_skip && !io_bad_func && io_data_out == io_data_in));

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> (ready_q && chr_q == $past(src_char) && !src_ready));

    // R2
    stop_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_op == 2'd0 && io_func == FUNC_W'(1)) |=> !src_ready);

    // R2
    start_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_op == 2'd0 && io_func == '0 && !hs) |=> src_ready);

    // R3
    ctrl_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_op == 2'd0 && io_func[FUNC_W-1:1] != '0) |-> io_bad_func);

    // R5
    skip_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_op == 2'd1 && io_func == '0) |-> (io_skip == ready_q));

    // R7
    take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_op == 2'd2 && io_func == '0 && ready_q && !hs)
        |=> !ready_q);

    // R11
    int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_enable && ready_q));

    // R12
    output_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_op == 2'd3 && !hs) |=> (ready_q == $past(ready_q)
                                                 && chr_q == $past(chr_q)));

endmodule

bind tape_reader_ctrl tape_reader_ctrl_chk #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W), .FUNC_W(FUNC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_op(io_op),
    .io_func(io_func), .io_data_in(io_data_in), .io_data_out(io_data_out),
    .io_skip(io_skip), .io_bad_func(io_bad_func), .int_enable(int_enable),
    .int_req(int_req), .src_valid(src_valid), .src_char(src_char),
    .src_ready(src_ready), .ready_q(ready_q), .chr_q(chr_q)
);

// File: tb/tape_reader_ctrl_bench.sv
`timescale 1ns/1ps
module tape_reader_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_strobe = 1'b0;
    logic [1:0]  io_op = 2'd0;
    logic [3:0]  io_func = 4'd0;
    logic [15:0] io_data_in = 16'h0;
    logic [15:0] io_data_out;
    logic        io_skip, io_bad_func;
    logic        int_enable = 1'b0;
    logic        int_req;
    logic        src_valid = 1'b0;
    logic [7:0]  src_char = 8'h0;
    logic        src_ready;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    tape_reader_ctrl u_tape_reader_ctrl (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one instruction for one cycle; answers sampled 1 ns after driving
    task automatic instr(input logic [1:0] op, input logic [3:0] fn, input logic [15:0] din,
                         output logic [15:0] dout, output logic sk, output logic bd);
        io_strobe = 1'b1; io_op = op; io_func = fn; io_data_in = din;
        #1;
        dout = io_data_out; sk = io_skip; bd = io_bad_func;
        @(negedge clk);
        io_strobe = 1'b0; io_data_in = 16'h0;
    endtask

    task automatic feed(input logic [7:0] ch);
        src_valid = 1'b1; src_char = ch;
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] d; logic s, b;
        chk("R1 src_ready", {15'h0, src_ready}, 16'h0);
        int_enable = 1'b1; #1;
        chk("R1 int_req", {15'h0, int_req}, 16'h0);
        int_enable = 1'b0;
        instr(2'd1, 4'd0, 16'h0, d, s, b);
        chk("R1 ready via skip0", {15'h0, s}, 16'h0);
    endtask

    task automatic t_idle;
        io_data_in = 16'hBEEF; io_op = 2'd2; io_func = 4'd0; #1;
        chk("R13 data", io_data_out, 16'hBEEF);
        chk("R13 skip/bad", {14'h0, io_skip, io_bad_func}, 16'h0);
        @(negedge clk); io_data_in = 16'h0;
    endtask

    task automatic t_start_capture;
        logic [15:0] d; logic s, b;
        instr(2'd0, 4'd0, 16'h0, d, s, b);
        chk("R2 start src_ready", {15'h0, src_ready}, 16'h1);
        feed(8'hA5);
        chk("R4 request dropped", {15'h0, src_ready}, 16'h0);
        instr(2'd1, 4'd0, 16'h0, d, s, b);
        chk("R4/R5 ready skip", {15'h0, s}, 16'h1);
        int_enable = 1'b1; #1;
        chk("R11 int_req on", {15'h0, int_req}, 16'h1);
        @(negedge clk);
        instr(2'd1, 4'd4, 16'h0, d, s, b);
        chk("R5 skip4 interrupting", {15'h0, s}, 16'h0);
        int_enable = 1'b0; #1;
        chk("R11 int_req masked", {15'h0, int_req}, 16'h0);
        @(negedge clk);
        instr(2'd1, 4'd4, 16'h0, d, s, b);
        chk("R5 skip4 quiet", {15'h0, s}, 16'h1);
    endtask

    task automatic t_bad;
        logic [15:0] d; logic s, b;
        instr(2'd0, 4'd2, 16'h1234, d, s, b);
        chk("R3 ctrl bad", {15'h0, b}, 16'h1);
        chk("R3 data", d, 16'h1234);
        instr(2'd0, 4'd9, 16'h0, d, s, b);
        chk("R3 ctrl bad 9", {15'h0, b}, 16'h1);
        chk("R3 motion kept", {15'h0, src_ready}, 16'h0);
        instr(2'd1, 4'd1, 16'h0, d, s, b);
        chk("R6 skip bad 1", {14'h0, s, b}, 16'h1);
        instr(2'd1, 4'd2, 16'h0, d, s, b);
        chk("R6 skip bad 2", {14'h0, s, b}, 16'h1);
        instr(2'd1, 4'd8, 16'h0, d, s, b);
        chk("R6 skip bad 8", {14'h0, s, b}, 16'h1);
        instr(2'd2, 4'd3, 16'h4000, d, s, b);
        chk("R9 input bad", {14'h0, s, b}, 16'h1);
        chk("R9 data", d, 16'h4000);
        instr(2'd1, 4'd0, 16'h0, d, s, b);
        chk("R9 ready kept", {15'h0, s}, 16'h1);
    endtask

    task automatic t_input;
        logic [15:0] d; logic s, b;
        instr(2'd2, 4'd0, 16'h1200, d, s, b);
        chk("R7 data", d, 16'h12A5);
        chk("R7 skip", {14'h0, s, b}, 16'h2);
        chk("R10 restart", {15'h0, src_ready}, 16'h1);
        instr(2'd1, 4'd0, 16'h0, d, s, b);
        chk("R7 ready cleared", {15'h0, s}, 16'h0);
        instr(2'd2, 4'd0, 16'h0F00, d, s, b);
        chk("R8 data", d, 16'h0F00);
        chk("R8 flags", {14'h0, s, b}, 16'h0);
    endtask

    task automatic t_stop;
        logic [15:0] d; logic s, b;
        feed(8'h3C);
        instr(2'd0, 4'd1, 16'h0, d, s, b);
        chk("R2 stop src_ready", {15'h0, src_ready}, 16'h0);
        instr(2'd2, 4'd0, 16'h8000, d, s, b);
        chk("R7 data stopped", d, 16'h803C);
        chk("R10 no restart", {15'h0, src_ready}, 16'h0);
        feed(8'hFF);
        instr(2'd1, 4'd0, 16'h0, d, s, b);
        chk("R4 valid ignored", {15'h0, s}, 16'h0);
    endtask

    task automatic t_output;
        logic [15:0] d; logic s, b;
        instr(2'd0, 4'd0, 16'h0, d, s, b);
        feed(8'h77);
        instr(2'd0, 4'd1, 16'h0, d, s, b);
        instr(2'd3, 4'd0, 16'h5555, d, s, b);
        chk("R12 data", d, 16'h5555);
        chk("R12 flags", {14'h0, s, b}, 16'h0);
        instr(2'd3, 4'd7, 16'h00FF, d, s, b);
        chk("R12 any func", {14'h0, s, b}, 16'h0);
        instr(2'd1, 4'd0, 16'h0, d, s, b);
        chk("R12 ready kept", {15'h0, s}, 16'h1);
        instr(2'd2, 4'd0, 16'h0, d, s, b);
        chk("R12 buffer kept", d, 16'h0077);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_start_capture();
        t_bad();
        t_input();
        t_stop();
        t_output();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule